// File: doc/BRIEF.md
# Regional Trigger-Latency Hit Buffer

This block buffers the hits of one region of four pixel cells. The four cells share a small pool of hit slots. When a cell's discriminator output rises, the block claims a slot and records three things: the bunch-crossing time stamp, the cell index within the region, and an amplitude. The amplitude is the time over threshold, counted in crossings. Each slot is held for a programmable trigger latency. When that latency runs out, the slot's hit is either queued towards the column end or dropped. It is queued only if a trigger pulse arrives on that exact crossing.

Queued hits leave through a valid/ready port, one per clock cycle. A hit that finds every slot occupied is lost and counted. The latency input is given in crossings and is eight bits wide. At a 25 ns crossing this covers the 3.2 µs, 4.0 µs and 6 µs operating points, which are 128, 160 and 240 crossings.

Top module: `region_hit_buffer`

## Requirements
- R1: While reset is asserted and right after it, `hit_valid_o` is 0 and `lost_cnt_o` is 0. The crossing counter restarts at 0.
- R2: Discriminators are sampled only on cycles with `bx_i` high, and a hit starts when a sample is 1 where the previous sample was 0. The hit takes the lowest-index free slot, and cells starting on the same crossing claim slots in ascending cell index. The slot records the crossing count and the cell index (0 to 3). The crossing count is 0 on the first strobe after reset and rises by 1 per strobe, modulo 2^TS_W.
- R3: The amplitude is the number of consecutive strobes on which the cell's sample is high, starting with the rising one, held in 3 bits. It saturates at 4.
- R4: A held hit expires on the strobe where (crossing count − stored stamp) mod 2^TS_W equals `latency_i`. If `trig_i` is high on that strobe the hit is forwarded; otherwise it is discarded. A trigger on any other strobe has no effect on that hit. `hit_valid_o` rises in the cycle after the expiring strobe.
- R5: A forwarded hit stays on the port with stable fields until `hit_ready_i` is high. Hits eligible in the same cycle leave in ascending slot index, one per cycle.
- R6: A rising edge that finds no free slot is lost. `lost_cnt_o` adds the number of hits lost on each strobe, saturates at 2^LOST_W − 1, and never changes on cycles without a strobe.
- R7: A slot is free again in the cycle after its hit is discarded or handed over, so a hit on the very next strobe can reuse it.
- R8: The pool holds NBUF slots, 5 by default. Latencies of 128, 160 and 240 crossings are accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bx_i | input | 1 | Bunch-crossing strobe, one cycle per crossing |
| disc_i | input | 4 | Discriminator outputs of the four cells |
| trig_i | input | 1 | Trigger for the crossing whose latency expires on this strobe |
| latency_i | input | LAT_W | Trigger latency in crossings |
| hit_valid_o | output | 1 | Forwarded hit available |
| hit_ready_i | input | 1 | Column end accepts the hit |
| hit_ts_o | output | TS_W | Crossing stamp of the hit |
| hit_pix_o | output | 2 | Cell index within the region |
| hit_tot_o | output | 3 | Time over threshold in crossings, 1 to 4 |
| lost_cnt_o | output | LOST_W | Saturating count of lost hits |

## Verification
A hit stamped on strobe T becomes visible on the port one clock after strobe T+latency. Each following entry arrives one clock after the previous one is accepted. The lost counter and the amplitude settle one clock after the strobe that changes them. The bench drives every input at the falling edge and counts its own strobes, so it can work out each stamp, amplitude and loss count by arithmetic. It samples all outputs at the falling edge that follows the strobe or handover in question. It sweeps every cell mask under three trigger placements (none, on expiry, and one crossing early), then runs directed sequences for a full pool, slot reuse, back-pressure, counter saturation and the longest latency.

// File: rtl/rhb_pkg.sv
package rhb_pkg;
  localparam int NPIX    = 4;
  localparam int PIX_W   = 2;
  localparam int TOT_W   = 3;
  localparam int TOT_MAX = 4;

  typedef enum logic [1:0] {
    SLOT_FREE = 2'd0,
    SLOT_HOLD = 2'd1,
    SLOT_SEND = 2'd2
  } slot_st_e;
endpackage

// File: rtl/rhb_front.sv
module rhb_front #(
  parameter int NPIX = 4
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            bx_i,
  input  logic [NPIX-1:0] disc_i,
  output logic [NPIX-1:0] rise_o,
  output logic [NPIX-1:0] cont_o
);
  logic [NPIX-1:0] samp_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   samp_q <= '0;
    else if (bx_i) samp_q <= disc_i;
  end

  assign rise_o = disc_i & ~samp_q;
  assign cont_o = disc_i & samp_q;
endmodule

// File: rtl/rhb_alloc.sv
module rhb_alloc #(
  parameter int NPIX  = 4,
  parameter int NBUF  = 5,
  parameter int BI_W  = 3,
  parameter int CNT_W = 3
) (
  input  logic [NPIX-1:0] rise_i,
  input  logic [NBUF-1:0] free_i,
  output logic [NPIX-1:0] gnt_vld_o,
  output logic [BI_W-1:0] gnt_idx_o [NPIX],
  output logic [CNT_W-1:0] lost_o
);
  logic [NBUF-1:0] avail;
  logic            found;

  // cells in ascending order, each takes the lowest still-free slot
  always_comb begin
    avail  = free_i;
    lost_o = '0;
    found  = 1'b0;
    for (int p = 0; p < NPIX; p++) begin
      gnt_vld_o[p] = 1'b0;
      gnt_idx_o[p] = '0;
      found        = 1'b0;
      if (rise_i[p]) begin
        for (int b = 0; b < NBUF; b++) begin
          if (!found && avail[b]) begin
            found        = 1'b1;
            gnt_idx_o[p] = BI_W'(b);
            avail[b]     = 1'b0;
          end
        end
        gnt_vld_o[p] = found;
        if (!found) lost_o = lost_o + CNT_W'(1);
      end
    end
  end
endmodule

// File: rtl/rhb_pick.sv
module rhb_pick #(
  parameter int N  = 5,
  parameter int IW = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [N-1:0]  req_i,
  input  logic          ready_i,
  output logic          vld_o,
  output logic [IW-1:0] idx_o
);
  logic [IW-1:0] first;
  logic          lock_q;
  logic [IW-1:0] lock_idx_q;

  always_comb begin
    first = '0;
    for (int b = N - 1; b >= 0; b--) begin
      if (req_i[b]) first = IW'(b);
    end
  end

  // a stalled entry keeps the port even if a lower slot becomes eligible
  assign vld_o = |req_i;
  assign idx_o = lock_q ? lock_idx_q : first;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lock_q     <= 1'b0;
      lock_idx_q <= '0;
    end else begin
      lock_q     <= vld_o && !ready_i;
      lock_idx_q <= idx_o;
    end
  end

  AST_PICK_LIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld_o |-> req_i[idx_o]); // R5
endmodule

// File: rtl/region_hit_buffer.sv
module region_hit_buffer
  import rhb_pkg::*;
#(
  parameter int NBUF   = 5,
  parameter int TS_W   = 8,
  parameter int LAT_W  = 8,
  parameter int LOST_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bx_i,
  input  logic [3:0]        disc_i,
  input  logic              trig_i,
  input  logic [LAT_W-1:0]  latency_i,
  output logic              hit_valid_o,
  input  logic              hit_ready_i,
  output logic [TS_W-1:0]   hit_ts_o,
  output logic [1:0]        hit_pix_o,
  output logic [2:0]        hit_tot_o,
  output logic [LOST_W-1:0] lost_cnt_o
);
  localparam int BI_W  = (NBUF > 1) ? $clog2(NBUF) : 1;
  localparam int CNT_W = $clog2(NPIX + 1);

  logic [TS_W-1:0]   bx_cnt_q;
  logic [NPIX-1:0]   rise, cont;
  logic [NBUF-1:0]   free_v, hold_v, send_v;
  logic [NPIX-1:0]   gnt_vld;
  logic [BI_W-1:0]   gnt_idx [NPIX];
  logic [CNT_W-1:0]  lost_add;
  logic [BI_W-1:0]   sel;
  logic              pop;
  logic [NPIX-1:0]   own_vld_q;
  logic [BI_W-1:0]   own_idx_q [NPIX];
  logic [TS_W-1:0]   ts_arr  [NBUF];
  logic [PIX_W-1:0]  pix_arr [NBUF];
  logic [TOT_W-1:0]  tot_arr [NBUF];
  logic [LOST_W-1:0] lost_q;
  logic [LOST_W:0]   lost_sum;

  rhb_front #(.NPIX(NPIX)) u_front (
    .clk_i, .rst_ni, .bx_i, .disc_i,
    .rise_o(rise), .cont_o(cont)
  );

  rhb_alloc #(.NPIX(NPIX), .NBUF(NBUF), .BI_W(BI_W), .CNT_W(CNT_W)) u_alloc (
    .rise_i(rise), .free_i(free_v),
    .gnt_vld_o(gnt_vld), .gnt_idx_o(gnt_idx), .lost_o(lost_add)
  );

  rhb_pick #(.N(NBUF), .IW(BI_W)) u_pick (
    .clk_i, .rst_ni, .req_i(send_v), .ready_i(hit_ready_i),
    .vld_o(hit_valid_o), .idx_o(sel)
  );

  assign pop = hit_valid_o && hit_ready_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   bx_cnt_q <= '0;
    else if (bx_i) bx_cnt_q <= bx_cnt_q + TS_W'(1);
  end

  // each cell remembers which slot accumulates its amplitude
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      own_vld_q <= '0;
      for (int p = 0; p < NPIX; p++) own_idx_q[p] <= '0;
    end else if (bx_i) begin
      for (int p = 0; p < NPIX; p++) begin
        if (rise[p]) begin
          own_vld_q[p] <= gnt_vld[p];
          own_idx_q[p] <= gnt_idx[p];
        end else if (!disc_i[p] || !hold_v[own_idx_q[p]]) begin
          own_vld_q[p] <= 1'b0;
        end
      end
    end
  end

  for (genvar b = 0; b < NBUF; b++) begin : g_slot
    slot_st_e         st_q;
    logic [TS_W-1:0]  ts_q;
    logic [PIX_W-1:0] pix_q;
    logic [TOT_W-1:0] tot_q;
    logic             a_v, i_v, exp_now, pop_me;
    logic [PIX_W-1:0] a_pix;
    logic [TS_W-1:0]  age;

    always_comb begin
      a_v   = 1'b0;
      a_pix = '0;
      i_v   = 1'b0;
      for (int p = 0; p < NPIX; p++) begin
        if (gnt_vld[p] && gnt_idx[p] == BI_W'(b)) begin
          a_v   = 1'b1;
          a_pix = PIX_W'(p);
        end
        if (own_vld_q[p] && own_idx_q[p] == BI_W'(b) && cont[p]) i_v = 1'b1;
      end
    end

    assign age     = bx_cnt_q - ts_q;
    assign exp_now = bx_i && st_q == SLOT_HOLD && age == TS_W'(latency_i);
    assign pop_me  = pop && sel == BI_W'(b);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        st_q  <= SLOT_FREE;
        ts_q  <= '0;
        pix_q <= '0;
        tot_q <= '0;
      end else begin
        if (exp_now) begin
          st_q <= trig_i ? SLOT_SEND : SLOT_FREE;
        end else if (st_q == SLOT_SEND && pop_me) begin
          st_q <= SLOT_FREE;
        end else if (bx_i && a_v) begin
          st_q  <= SLOT_HOLD;
          ts_q  <= bx_cnt_q;
          pix_q <= a_pix;
          tot_q <= TOT_W'(1);
        end
        if (bx_i && st_q == SLOT_HOLD && i_v && !exp_now && tot_q < TOT_W'(TOT_MAX))
          tot_q <= tot_q + TOT_W'(1);
      end
    end

    assign free_v[b]  = st_q == SLOT_FREE;
    assign hold_v[b]  = st_q == SLOT_HOLD;
    assign send_v[b]  = st_q == SLOT_SEND;
    assign ts_arr[b]  = ts_q;
    assign pix_arr[b] = pix_q;
    assign tot_arr[b] = tot_q;
  end

  assign hit_ts_o  = ts_arr[sel];
  assign hit_pix_o = pix_arr[sel];
  assign hit_tot_o = tot_arr[sel];

  assign lost_sum = {1'b0, lost_q} + (LOST_W + 1)'(lost_add);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   lost_q <= '0;
    else if (bx_i) lost_q <= lost_sum[LOST_W] ? '1 : lost_sum[LOST_W-1:0];
  end

  assign lost_cnt_o = lost_q;

  AST_HOLD_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_valid_o && !hit_ready_i |=> hit_valid_o && $stable(hit_ts_o)
      && $stable(hit_pix_o) && $stable(hit_tot_o)); // R5
  AST_TOT_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_valid_o |-> hit_tot_o >= 3'd1 && hit_tot_o <= 3'd4); // R3
  AST_LOST_MONO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> lost_cnt_o >= $past(lost_cnt_o)); // R6
  AST_LOST_ON_BX: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bx_i |=> $stable(lost_cnt_o)); // R6
  AST_SEND_AFTER_BX: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(hit_valid_o) |-> $past(bx_i)); // R4
endmodule

// File: tb/region_hit_buffer_test.sv
module region_hit_buffer_test;
  localparam int CLK_PER = 10;
  localparam int WD_CYC  = 150000;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       bx_i = 1'b0;
  logic [3:0] disc_i = '0;
  logic       trig_i = 1'b0;
  logic [7:0] latency_i = 8'd8;
  logic       hit_valid_o;
  logic       hit_ready_i = 1'b0;
  logic [7:0] hit_ts_o;
  logic [1:0] hit_pix_o;
  logic [2:0] hit_tot_o;
  logic [7:0] lost_cnt_o;

  int n_chk  = 0;
  int n_fail = 0;
  int bxn    = 0;
  int exp_lost = 0;

  always #(CLK_PER / 2) clk_i = ~clk_i;

  region_hit_buffer uut (
    .clk_i, .rst_ni, .bx_i, .disc_i, .trig_i, .latency_i,
    .hit_valid_o, .hit_ready_i, .hit_ts_o, .hit_pix_o, .hit_tot_o, .lost_cnt_o
  );

  task automatic chk(input string req, input int act, input int expv);
    n_chk++;
    if (act != expv) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic strobe(input logic [3:0] d, input logic t);
    @(negedge clk_i);
    disc_i = d;
    trig_i = t;
    bx_i   = 1'b1;
    @(negedge clk_i);
    bx_i   = 1'b0;
    trig_i = 1'b0;
    bxn++;
  endtask

  task automatic expect_hit(input string req, input int pix, input int ts, input int tot);
    chk({req, " valid"}, int'(hit_valid_o), 1);
    chk({req, " pix"}, int'(hit_pix_o), pix);
    chk({req, " ts"}, int'(hit_ts_o), ts % 256);
    chk({req, " tot"}, int'(hit_tot_o), tot);
  endtask

  function automatic int plen(input int p, input int m);
    return ((p + m) % 6) + 1;
  endfunction

  initial begin
    repeat (WD_CYC) @(posedge clk_i);
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", WD_CYC, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    int t0;
    logic [3:0] d;
    repeat (3) @(negedge clk_i);
    chk("R1 reset valid", int'(hit_valid_o), 0);
    chk("R1 reset lost", int'(lost_cnt_o), 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R1 after reset valid", int'(hit_valid_o), 0);

    // R2 R3 R4 R5: every mask, trigger absent / on expiry / one crossing early
    latency_i = 8'd8;
    for (int mode = 0; mode < 3; mode++) begin
      for (int m = 1; m < 16; m++) begin
        t0 = bxn;
        for (int k = 0; k <= 8; k++) begin
          for (int p = 0; p < 4; p++) d[p] = m[p] && (k < plen(p, m));
          strobe(d, (mode == 1 && k == 8) || (mode == 2 && k == 7));
        end
        hit_ready_i = 1'b1;
        if (mode == 1) begin
          for (int p = 0; p < 4; p++) begin
            if (m[p]) begin
              expect_hit("R4 R2 R3 R5 sweep", p, t0, (plen(p, m) > 4) ? 4 : plen(p, m));
              @(negedge clk_i);
            end
          end
        end
        chk("R4 no further hit", int'(hit_valid_o), 0);
        hit_ready_i = 1'b0;
        chk("R6 no loss in sweep", int'(lost_cnt_o), exp_lost);
      end
    end

    // R6 R7: full pool, losses, reuse on the crossing after discard
    t0 = bxn;
    strobe(4'b1111, 1'b0);
    strobe(4'b0000, 1'b0);
    strobe(4'b0001, 1'b0);
    strobe(4'b0000, 1'b0);
    strobe(4'b0110, 1'b0);
    exp_lost += 2;
    chk("R6 lost when full", int'(lost_cnt_o), exp_lost);
    strobe(4'b0000, 1'b0);
    strobe(4'b0000, 1'b0);
    strobe(4'b0000, 1'b0);
    strobe(4'b0000, 1'b0);
    chk("R4 discard without trigger", int'(hit_valid_o), 0);
    strobe(4'b1110, 1'b0);
    chk("R7 reuse freed slots", int'(lost_cnt_o), exp_lost);
    strobe(4'b1110, 1'b1);
    hit_ready_i = 1'b1;
    expect_hit("R4 late slot", 0, t0 + 2, 1);
    @(negedge clk_i);
    chk("R5 single hit", int'(hit_valid_o), 0);
    hit_ready_i = 1'b0;
    for (int k = 11; k < 17; k++) strobe(4'b0000, 1'b0);
    strobe(4'b0000, 1'b1);
    repeat (3) begin
      expect_hit("R5 stall keeps first", 1, t0 + 9, 2);
      @(negedge clk_i);
    end
    hit_ready_i = 1'b1;
    for (int p = 1; p < 4; p++) begin
      expect_hit("R7 R5 reused slots in order", p, t0 + 9, 2);
      @(negedge clk_i);
    end
    chk("R5 drained", int'(hit_valid_o), 0);
    hit_ready_i = 1'b0;

    // R6: saturation with long latency
    latency_i = 8'd200;
    t0 = bxn;
    strobe(4'b1111, 1'b0);
    strobe(4'b0000, 1'b0);
    strobe(4'b0001, 1'b0);
    strobe(4'b0000, 1'b0);
    for (int k = 0; k < 70; k++) begin
      strobe(4'b1111, 1'b0);
      exp_lost = (exp_lost + 4 > 255) ? 255 : exp_lost + 4;
      strobe(4'b0000, 1'b0);
      if (k == 10) chk("R6 count mid run", int'(lost_cnt_o), exp_lost);
    end
    chk("R6 saturated", int'(lost_cnt_o), 255);
    while (bxn <= t0 + 203) strobe(4'b0000, 1'b0);
    chk("R4 long latency discard", int'(hit_valid_o), 0);
    chk("R6 holds at max", int'(lost_cnt_o), 255);

    // R8: longest operating point, stamp wraps
    latency_i = 8'd240;
    t0 = bxn;
    for (int k = 0; k < 240; k++) strobe((k < 5) ? 4'b1000 : 4'b0000, 1'b0);
    chk("R8 not yet expired", int'(hit_valid_o), 0);
    strobe(4'b0000, 1'b1);
    hit_ready_i = 1'b1;
    expect_hit("R8 latency 240", 3, t0, 4);
    @(negedge clk_i);
    chk("R8 drained", int'(hit_valid_o), 0);
    hit_ready_i = 1'b0;

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule